// File: doc/BRIEF.md
# Saturating Gain-Adjust Barrel Shifter

This block multiplies a signed sample stream by a power of two. The shift amount is the sum of two terms. One is a 4-bit base code, which normally comes from a configuration register. The other is a 3-bit gain-adjust input, driven live by surrounding logic. Each unit of shift adds 6 dB of gain. The sum is clamped at the largest 4-bit code and never wraps to a small shift.

The sample, its valid strobe, the base code and the gain-adjust value are all captured on the same rising clock edge. The scaled result leaves through a register one clock later. The output register is wide enough to hold a full-scale input shifted by the maximum code, so it never overflows. When no valid sample arrives, the output word keeps its last value.

Top module: `gain_shift_top`

## Requirements
- R1: When base code plus gain-adjust is 15 or less, the effective shift is their plain unsigned sum. The gain-adjust bit 2 carries weight 4, bit 1 weight 2 and bit 0 weight 1.
- R2: When base code plus gain-adjust exceeds 15, the effective shift is 15. It never wraps.
- R3: A valid sample appears on `y_data` as its 32-bit sign-extended value times 2 to the power of the effective shift, in two's complement. All inputs are taken from the same cycle as the sample.
- R4: `y_valid` is high in exactly the cycles that directly follow a cycle in which `x_valid` was high and reset was low.
- R5: In the cycle after one with `x_valid` low, `y_data` keeps its previous value, whatever `x_data`, `base_shift` or `gain_adj` carry.
- R6: In the cycle after synchronous reset is high, `y_valid` is 0 and `y_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| x_valid | input | 1 | Input sample valid |
| x_data | input | 16 | Signed input sample |
| base_shift | input | 4 | Base shift code, unsigned |
| gain_adj | input | 3 | Gain-adjust offset, unsigned, bit 2 is the MSB |
| y_valid | output | 1 | Output sample valid |
| y_data | output | 32 | Signed scaled sample |

## Verification
Every result is due exactly one clock after the edge that captures its inputs: the valid strobe, the scaled word, the held word after an idle cycle, and the cleared state after reset.

The bench drives all inputs on the falling edge. A behavioural model advances on the rising edge and predicts the next output. The ports are compared on the following falling edge, so every comparison looks at the one register stage and nothing earlier.

Directed cases sit on both sides of the clamp point: sums of 15, 16 and 22, and each gain-adjust bit on its own. Pseudo-random traffic and a mid-run reset then follow.

// File: rtl/gain_shift_pkg.sv
package gain_shift_pkg;

    localparam int unsigned SAMPLE_W = 16;
    localparam int unsigned CODE_W   = 4;
    localparam int unsigned ADJ_W    = 3;
    localparam int unsigned RESULT_W = 32;

    // Largest code a CODE_W field can hold
    function automatic int unsigned code_ceiling(input int unsigned width);
        return (1 << width) - 1;
    endfunction

    // Width needed for the unclamped sum of two unsigned fields
    function automatic int unsigned sum_width(input int unsigned a_w, input int unsigned b_w);
        return ((a_w > b_w) ? a_w : b_w) + 1;
    endfunction

    typedef struct packed {
        logic                       valid;
        logic signed [RESULT_W-1:0] data;
    } scaled_t;

endpackage

// File: rtl/gain_shift_sat.sv
module gain_shift_sat #(
    parameter int unsigned CODE_W = 4,
    parameter int unsigned ADJ_W  = 3
) (
    input  logic [CODE_W-1:0] base_code,
    input  logic [ADJ_W-1:0]  adj_code,
    output logic [CODE_W-1:0] eff_code
);
    import gain_shift_pkg::*;

    localparam int unsigned SUM_W = sum_width(CODE_W, ADJ_W);
    localparam logic [SUM_W-1:0] CEIL = SUM_W'(code_ceiling(CODE_W));

    logic [SUM_W-1:0] raw_sum;

    always_comb begin
        raw_sum = SUM_W'(base_code) + SUM_W'(adj_code);
        if (raw_sum > CEIL) begin
            eff_code = CEIL[CODE_W-1:0];
        end else begin
            eff_code = raw_sum[CODE_W-1:0];
        end
    end

endmodule

// File: rtl/gain_shift_barrel.sv
module gain_shift_barrel #(
    parameter int unsigned IN_W  = 16,
    parameter int unsigned OUT_W = 32,
    parameter int unsigned SH_W  = 4
) (
    input  logic signed [IN_W-1:0]  din,
    input  logic        [SH_W-1:0]  amount,
    output logic signed [OUT_W-1:0] dout
);
    localparam int unsigned EXT_W = OUT_W - IN_W;

    logic signed [OUT_W-1:0] stage [0:SH_W];

    assign stage[0] = {{EXT_W{din[IN_W-1]}}, din};

    // One conditional shift by 2**k per bit of the shift amount
    generate
        for (genvar k = 0; k < SH_W; k++) begin : g_stage
            assign stage[k+1] = amount[k] ? (stage[k] <<< (1 << k)) : stage[k];
        end
    endgenerate

    assign dout = stage[SH_W];

endmodule

// File: rtl/gain_shift_reg.sv
module gain_shift_reg #(
    parameter int unsigned OUT_W = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    load,
    input  logic signed [OUT_W-1:0] next_data,
    output logic                    q_valid,
    output logic signed [OUT_W-1:0] q_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q_valid <= 1'b0;
            q_data  <= '0;
        end else begin
            q_valid <= load;
            if (load) begin
                q_data <= next_data;
            end
        end
    end

endmodule

// File: rtl/gain_shift_top.sv
module gain_shift_top #(
    parameter int unsigned SAMPLE_W = gain_shift_pkg::SAMPLE_W,
    parameter int unsigned CODE_W   = gain_shift_pkg::CODE_W,
    parameter int unsigned ADJ_W    = gain_shift_pkg::ADJ_W,
    parameter int unsigned RESULT_W = gain_shift_pkg::RESULT_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       x_valid,
    input  logic signed [SAMPLE_W-1:0] x_data,
    input  logic        [CODE_W-1:0]   base_shift,
    input  logic        [ADJ_W-1:0]    gain_adj,
    output logic                       y_valid,
    output logic signed [RESULT_W-1:0] y_data
);
    logic        [CODE_W-1:0]   eff_shift;
    logic signed [RESULT_W-1:0] shifted;

    gain_shift_sat #(
        .CODE_W (CODE_W),
        .ADJ_W  (ADJ_W)
    ) u_sat (
        .base_code (base_shift),
        .adj_code  (gain_adj),
        .eff_code  (eff_shift)
    );

    gain_shift_barrel #(
        .IN_W  (SAMPLE_W),
        .OUT_W (RESULT_W),
        .SH_W  (CODE_W)
    ) u_barrel (
        .din    (x_data),
        .amount (eff_shift),
        .dout   (shifted)
    );

    gain_shift_reg #(
        .OUT_W (RESULT_W)
    ) u_reg (
        .clk       (clk),
        .rst       (rst),
        .load      (x_valid),
        .next_data (shifted),
        .q_valid   (y_valid),
        .q_data    (y_data)
    );

endmodule

// File: rtl/gain_shift_chk.sv
module gain_shift_chk #(
    parameter int unsigned SAMPLE_W = 16,
    parameter int unsigned CODE_W   = 4,
    parameter int unsigned ADJ_W    = 3,
    parameter int unsigned RESULT_W = 32
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       x_valid,
    input logic signed [SAMPLE_W-1:0] x_data,
    input logic        [CODE_W-1:0]   base_shift,
    input logic        [ADJ_W-1:0]    gain_adj,
    input logic                       y_valid,
    input logic signed [RESULT_W-1:0] y_data
);
    localparam int unsigned SUM_W = ((CODE_W > ADJ_W) ? CODE_W : ADJ_W) + 1;
    localparam logic [SUM_W-1:0] CEIL = SUM_W'((1 << CODE_W) - 1);

    logic        [SUM_W-1:0]    sum_c;
    logic signed [RESULT_W-1:0] x_ext;
    logic signed [RESULT_W-1:0] x_ceil;

    assign sum_c  = SUM_W'(base_shift) + SUM_W'(gain_adj);
    assign x_ext  = RESULT_W'(x_data);
    assign x_ceil = x_ext <<< CEIL;

    // R4
    vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
        x_valid |=> y_valid);

    // R4
    vld_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !x_valid |=> !y_valid);

    // R5
    hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !x_valid |=> $stable(y_data));

    // R2
    clamp_max_chk: assert property (@(posedge clk) disable iff (rst)
        (x_valid && (sum_c > CEIL)) |=> (y_data == $past(x_ceil)));

    // R1
    zero_shift_chk: assert property (@(posedge clk) disable iff (rst)
        (x_valid && (sum_c == '0)) |=> (y_data == $past(x_ext)));

    // R6
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!y_valid && (y_data == '0)));

endmodule

bind gain_shift_top gain_shift_chk #(
    .SAMPLE_W (SAMPLE_W),
    .CODE_W   (CODE_W),
    .ADJ_W    (ADJ_W),
    .RESULT_W (RESULT_W)
) i_gain_shift_chk (
    .clk        (clk),
    .rst        (rst),
    .x_valid    (x_valid),
    .x_data     (x_data),
    .base_shift (base_shift),
    .gain_adj   (gain_adj),
    .y_valid    (y_valid),
    .y_data     (y_data)
);

// File: tb/test_gain_shift_top.sv
`timescale 1ns/1ps
module test_gain_shift_top;

    localparam int CLK_PERIOD = 10;

    logic               clk = 1'b0;
    logic               rst;
    logic               x_valid;
    logic signed [15:0] x_data;
    logic        [3:0]  base_shift;
    logic        [2:0]  gain_adj;
    logic               y_valid;
    logic signed [31:0] y_data;

    int n_checks = 0;
    int n_fails  = 0;

    // Reference state
    logic        exp_valid = 1'b0;
    logic [31:0] exp_data  = '0;
    string       exp_tag   = "R6";
    logic [15:0] lfsr      = 16'hACE1;

    gain_shift_top i_gain_shift_top (
        .clk        (clk),
        .rst        (rst),
        .x_valid    (x_valid),
        .x_data     (x_data),
        .base_shift (base_shift),
        .gain_adj   (gain_adj),
        .y_valid    (y_valid),
        .y_data     (y_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural model: update on the same edge the design captures
    always @(posedge clk) begin
        int  sh;
        longint prod;
        sh = int'(base_shift) + int'(gain_adj);
        if (rst) begin
            exp_valid <= 1'b0;
            exp_data  <= '0;
            exp_tag   <= "R6";
        end else if (x_valid) begin
            exp_valid <= 1'b1;
            if (sh > 15) begin
                sh = 15;
                exp_tag <= "R2";
            end else begin
                exp_tag <= "R1 R3";
            end
            prod = longint'(x_data) * (longint'(1) << sh);
            exp_data <= prod[31:0];
        end else begin
            exp_valid <= 1'b0;
            exp_tag   <= "R5";
        end
    end

    task automatic compare();
        n_checks++;
        if (y_valid !== exp_valid) begin
            n_fails++;
            $display("FAIL R4 y_valid actual=%b expected=%b at %0t", y_valid, exp_valid, $time);
        end
        n_checks++;
        if (y_data !== exp_data) begin
            n_fails++;
            $display("FAIL %s y_data actual=%h expected=%h at %0t", exp_tag, y_data, exp_data, $time);
        end
    endtask

    task automatic step(input logic r, input logic v, input logic [15:0] d,
                        input logic [3:0] c, input logic [2:0] a);
        rst        = r;
        x_valid    = v;
        x_data     = d;
        base_shift = c;
        gain_adj   = a;
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fails++;
        $display("FAIL watchdog expired at %0t", $time);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        rst = 1'b1; x_valid = 1'b0; x_data = '0; base_shift = '0; gain_adj = '0;
        @(negedge clk);
        // R6 reset state
        step(1, 1, 16'h1234, 4'd3, 3'd1);
        step(1, 0, 16'h0000, 4'd0, 3'd0);
        // R1 R3 plain sums
        step(0, 1, 16'h0001, 4'd0, 3'd0);
        step(0, 1, 16'h0003, 4'd5, 3'd3);
        step(0, 1, 16'hFFFF, 4'd2, 3'd0);
        // R1 each gain-adjust bit alone
        step(0, 1, 16'h0001, 4'd0, 3'd1);
        step(0, 1, 16'h0001, 4'd0, 3'd2);
        step(0, 1, 16'h0001, 4'd0, 3'd4);
        // R1 sum exactly 15, R2 sums 16 and 22
        step(0, 1, 16'h7FFF, 4'd12, 3'd3);
        step(0, 1, 16'h7FFF, 4'd13, 3'd3);
        step(0, 1, 16'h8000, 4'd15, 3'd7);
        step(0, 1, 16'h8001, 4'd9, 3'd7);
        // R5 hold while idle with busy inputs
        step(0, 0, 16'h5555, 4'd1, 3'd1);
        step(0, 0, 16'hAAAA, 4'd7, 3'd6);
        // R4 back-to-back then idle
        step(0, 1, 16'h00F0, 4'd4, 3'd0);
        step(0, 1, 16'hFF10, 4'd0, 3'd4);
        step(0, 0, 16'h0000, 4'd0, 3'd0);
        // pseudo-random traffic with a mid-run reset
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step((i == 200), lfsr[0] | lfsr[5], {lfsr[7:0], lfsr[15:8]} ^ 16'(i * 37),
                 lfsr[11:8], lfsr[3:1]);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule